// File: doc/BRIEF.md
# Serial Unlock-Sequence Detector with Transfer Window

This block sits beside an SRAM-style bus and watches the memory cycles addressed to it. It looks for a fixed 64-bit key that a host writes one bit per bus cycle on data bit 0. Each matching write moves a key pointer forward. The first wrong bit locks out matching for all later writes. Any read clears both the pointer and the lockout.

When the whole key has matched, the block opens a transfer window. The window lasts for exactly 64 further enabled bus cycles. In each of those cycles one bit moves between the bus and a 64-bit timekeeping shadow register, least significant bit first. A write cycle shifts a bit in. A read cycle drives a bit out on data bit 0 while the cycle lasts. If the window contained any write, the captured word is committed to the shadow register when the window closes. The shadow register can also be preset through a plain load port.

Bus strobes are brought into the clock domain through synchronisers. A cycle is recognised on the rising edge of the synchronised "selected and (read or write)" strobe. A cycle is a write when write enable is active and a read otherwise. Cycles that do not assert chip enable are invisible to the block.

Top module: `serial_unlock_port`

## Requirements
- R1: During and after synchronous reset the window is closed, `bus_dq_oe` is low, the key pointer is 0 and `shadow_q` is 0.
- R2: 64 consecutive selected write cycles carrying key bit i on `bus_dq_in` in the i-th write (least significant bit first), starting from pointer 0, open the window (`window_open` = 1).
- R3: After a write whose data differs from the key bit at the pointer, the pointer stops advancing and all later writes are ignored for matching, so the window does not open even if the remaining key bits are correct.
- R4: A selected read cycle outside the window resets the pointer to bit 0 and clears the lockout, so a following full key opens the window.
- R5: Bus cycles with `bus_ce_n` high have no effect on the key sequence, the transfer count, `bus_dq_oe` or the shadow register.
- R6: The window stays open for exactly 64 selected cycles, then closes, and the next cycles are matched against the key from bit 0 again.
- R7: In the k-th window cycle (k = 0..63), if that cycle is a read, `bus_dq_oe` is 1 while the cycle lasts and `bus_dq_out` carries bit k of the transfer word, which is loaded from `shadow_q` when the window opens.
- R8: A write in the k-th window cycle places `bus_dq_in` at bit k of the transfer word. When the window closes after a window that contained a write, the word is copied to `shadow_q`.
- R9: A window with only reads leaves `shadow_q` unchanged. Outside a commit, `shadow_load_en` = 1 copies `shadow_load_data` into `shadow_q` on the next clock.
- R10: `bus_dq_oe` is low outside the window, and during write cycles.
- R11: A bus cycle counts once, on the rising edge of its synchronised strobe, however long the strobe is held.
- R12: A run of 64 reads outside the window, the flush recommended after power-up, leaves the window closed and the pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable for this block, active low |
| bus_oe_n | input | 1 | Output enable (read strobe), active low |
| bus_we_n | input | 1 | Write enable (write strobe), active low |
| bus_dq_in | input | 1 | Data bit 0 from the bus |
| bus_dq_out | output | 1 | Data bit 0 driven during window reads |
| bus_dq_oe | output | 1 | Drive enable for bus_dq_out |
| window_open | output | 1 | High while the transfer window is open |
| shadow_load_en | input | 1 | Preset strobe for the shadow register |
| shadow_load_data | input | XFER_BITS | Preset value for the shadow register |
| shadow_q | output | XFER_BITS | Shadow register contents |

## Verification
The assertions assume that each bus strobe stays active, and then inactive, for several clocks. Otherwise a cycle could be lost in the synchronisers. They also assume the preset port is not used while a window is open. The bench holds each cycle's strobes for five clocks and its idle gaps for five clocks. It leaves `bus_dq_in` stable for the whole cycle and uses the preset port only outside the window. Random runs mix partial keys, keys with a wrong bit, interleaved deselected cycles and mixed read/write windows. A bench model predicts the pointer, the lockout, the window count and the shadow contents.

// File: rtl/sul_pkg.sv
package sul_pkg;

  typedef enum logic {
    CYC_READ  = 1'b0,
    CYC_WRITE = 1'b1
  } cyc_kind_e;

  typedef struct packed {
    logic      start;
    cyc_kind_e kind;
    logic      din;
  } bus_evt_t;

endpackage

// File: rtl/sul_bus_sync.sv
module sul_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              din,
  output sul_pkg::bus_evt_t evt,
  output logic              strobe_level
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] ce_s, oe_s, we_s, d_s;
  logic                   act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_s  <= '1;
      oe_s  <= '1;
      we_s  <= '1;
      d_s   <= '0;
      act_q <= 1'b0;
    end else begin
      ce_s  <= {ce_s[SYNC_STAGES-2:0], ce_n};
      oe_s  <= {oe_s[SYNC_STAGES-2:0], oe_n};
      we_s  <= {we_s[SYNC_STAGES-2:0], we_n};
      d_s   <= {d_s[SYNC_STAGES-2:0], din};
      act_q <= strobe_level;
    end
  end

  always_comb begin
    strobe_level = ~ce_s[TOP] & (~oe_s[TOP] | ~we_s[TOP]);
    evt.start    = strobe_level & ~act_q;
    evt.kind     = we_s[TOP] ? sul_pkg::CYC_READ : sul_pkg::CYC_WRITE;
    evt.din      = d_s[TOP];
  end
endmodule

// File: rtl/sul_key_matcher.sv
module sul_key_matcher #(
  parameter int                    KEY_BITS = 64,
  parameter logic [KEY_BITS-1:0]   KEY      = '0,
  localparam int                   PTR_W    = $clog2(KEY_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  sul_pkg::bus_evt_t evt,
  input  logic              enable,
  output logic [PTR_W-1:0]  ptr,
  output logic              locked,
  output logic              unlock
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(KEY_BITS - 1);

  logic is_wr, hit;

  always_comb begin
    is_wr  = (evt.kind == sul_pkg::CYC_WRITE);
    hit    = (evt.din == KEY[ptr]);
    unlock = enable & evt.start & is_wr & ~locked & hit & (ptr == PTR_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      locked <= 1'b0;
    end else if (enable && evt.start) begin
      if (!is_wr) begin
        ptr    <= '0;
        locked <= 1'b0;
      end else if (!locked) begin
        if (!hit)
          locked <= 1'b1;
        else if (ptr == PTR_LAST)
          ptr <= '0;
        else
          ptr <= ptr + PTR_W'(1);
      end
    end
  end
endmodule

// File: rtl/sul_xfer_engine.sv
module sul_xfer_engine #(
  parameter int  XFER_BITS = 64,
  localparam int CNT_W     = $clog2(XFER_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  sul_pkg::bus_evt_t    evt,
  input  logic                 strobe_level,
  input  logic                 unlock,
  input  logic [XFER_BITS-1:0] shadow_q,
  output logic                 active,
  output logic [CNT_W-1:0]     cnt,
  output logic                 dq_out,
  output logic                 dq_oe,
  output logic                 commit,
  output logic [XFER_BITS-1:0] commit_data
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(XFER_BITS);

  logic [XFER_BITS-1:0] sr;
  logic                 wrote;
  logic                 is_wr, bit_in, full;

  always_comb begin
    is_wr       = (evt.kind == sul_pkg::CYC_WRITE);
    bit_in      = is_wr ? evt.din : sr[0];
    full        = (cnt == CNT_FULL);
    commit      = active & full & ~strobe_level & wrote;
    commit_data = sr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      sr     <= '0;
      wrote  <= 1'b0;
      dq_out <= 1'b0;
      dq_oe  <= 1'b0;
    end else begin
      if (!strobe_level) dq_oe <= 1'b0;
      if (unlock) begin
        active <= 1'b1;
        cnt    <= '0;
        sr     <= shadow_q;
        wrote  <= 1'b0;
      end else if (active) begin
        if (evt.start && !full) begin
          sr  <= {bit_in, sr[XFER_BITS-1:1]};
          cnt <= cnt + CNT_W'(1);
          if (is_wr) begin
            wrote <= 1'b1;
          end else begin
            dq_out <= sr[0];
            dq_oe  <= 1'b1;
          end
        end else if (full && !strobe_level) begin
          active <= 1'b0;
          cnt    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sul_shadow_reg.sv
module sul_shadow_reg #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [WIDTH-1:0] commit_data,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (commit)  q <= commit_data;
    else if (load_en) q <= load_data;
  end
endmodule

// File: rtl/serial_unlock_port.sv
module serial_unlock_port #(
  parameter int                  KEY_BITS    = 64,
  parameter int                  XFER_BITS   = 64,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [KEY_BITS-1:0] KEY         = 64'hC3A5_0F96_E17B_2D48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_ce_n,
  input  logic                 bus_oe_n,
  input  logic                 bus_we_n,
  input  logic                 bus_dq_in,
  output logic                 bus_dq_out,
  output logic                 bus_dq_oe,
  output logic                 window_open,
  input  logic                 shadow_load_en,
  input  logic [XFER_BITS-1:0] shadow_load_data,
  output logic [XFER_BITS-1:0] shadow_q
);
  localparam int PTR_W = $clog2(KEY_BITS);
  localparam int CNT_W = $clog2(XFER_BITS + 1);

  sul_pkg::bus_evt_t    evt;
  logic                 strobe_level;
  logic [PTR_W-1:0]     key_ptr;
  logic                 locked, unlock;
  logic [CNT_W-1:0]     xfer_cnt;
  logic                 commit;
  logic [XFER_BITS-1:0] commit_data;
  logic                 cyc_start, cyc_write;

  assign cyc_start = evt.start;
  assign cyc_write = (evt.kind == sul_pkg::CYC_WRITE);

  sul_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
    .din(bus_dq_in), .evt(evt), .strobe_level(strobe_level)
  );

  sul_key_matcher #(.KEY_BITS(KEY_BITS), .KEY(KEY)) u_match (
    .clk(clk), .rst(rst), .evt(evt), .enable(~window_open),
    .ptr(key_ptr), .locked(locked), .unlock(unlock)
  );

  sul_xfer_engine #(.XFER_BITS(XFER_BITS)) u_xfer (
    .clk(clk), .rst(rst), .evt(evt), .strobe_level(strobe_level),
    .unlock(unlock), .shadow_q(shadow_q), .active(window_open),
    .cnt(xfer_cnt), .dq_out(bus_dq_out), .dq_oe(bus_dq_oe),
    .commit(commit), .commit_data(commit_data)
  );

  sul_shadow_reg #(.WIDTH(XFER_BITS)) u_shadow (
    .clk(clk), .rst(rst), .commit(commit), .commit_data(commit_data),
    .load_en(shadow_load_en), .load_data(shadow_load_data), .q(shadow_q)
  );
endmodule

// File: rtl/sul_checker.sv
module sul_checker #(
  parameter int  KEY_BITS  = 64,
  parameter int  XFER_BITS = 64,
  localparam int PTR_W     = $clog2(KEY_BITS),
  localparam int CNT_W     = $clog2(XFER_BITS + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cyc_start,
  input logic                 cyc_write,
  input logic                 window_open,
  input logic                 dq_oe,
  input logic [PTR_W-1:0]     key_ptr,
  input logic                 locked,
  input logic [CNT_W-1:0]     xfer_cnt,
  input logic                 shadow_load_en,
  input logic [XFER_BITS-1:0] shadow_q
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(KEY_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(XFER_BITS);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!window_open && !dq_oe && key_ptr == '0)); // R1

  AST_OPEN_AFTER_FULL_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(window_open) |-> ($past(key_ptr) == PTR_LAST)); // R2

  AST_LOCK_FREEZES_PTR: assert property (@(posedge clk) disable iff (rst)
    (locked && !window_open && !(cyc_start && !cyc_write)) |=> (locked && $stable(key_ptr))); // R3

  AST_READ_REWINDS: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !cyc_write && !window_open) |=> (key_ptr == '0 && !locked)); // R4

  AST_WINDOW_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    window_open |-> (xfer_cnt <= CNT_FULL)); // R6

  AST_DRIVE_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> window_open); // R10

  AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!window_open && !shadow_load_en) |=> $stable(shadow_q)); // R9
endmodule

bind serial_unlock_port sul_checker #(.KEY_BITS(KEY_BITS), .XFER_BITS(XFER_BITS)) u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_write(cyc_write),
  .window_open(window_open), .dq_oe(bus_dq_oe), .key_ptr(key_ptr),
  .locked(locked), .xfer_cnt(xfer_cnt), .shadow_load_en(shadow_load_en),
  .shadow_q(shadow_q)
);

// File: tb/serial_unlock_port_tb.sv
module serial_unlock_port_tb;
  localparam int          NB  = 64;
  localparam logic [63:0] KEY = 64'hC3A5_0F96_E17B_2D48;

  logic clk = 1'b0, rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dq_in = 1'b0;
  logic dq_out, dq_oe, win;
  logic ld_en = 1'b0;
  logic [NB-1:0] ld_data = '0, shq;

  int checks = 0, errors = 0, clk_count = 0;
  bit finished = 0;

  // bench model
  int          m_ptr = 0, m_cnt = 0;
  bit          m_lock = 0, m_win = 0, m_wrote = 0;
  logic [63:0] m_sr = '0, m_shadow = '0;

  always #5 clk = ~clk;

  serial_unlock_port #(.KEY_BITS(NB), .XFER_BITS(NB), .KEY(KEY)) u_dut (
    .clk(clk), .rst(rst), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_dq_in(dq_in), .bus_dq_out(dq_out), .bus_dq_oe(dq_oe), .window_open(win),
    .shadow_load_en(ld_en), .shadow_load_data(ld_data), .shadow_q(shq)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    clk_count++;
    if (clk_count > 190000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model update from requirements R2..R8
  function automatic void model_step(input bit wr, input bit din);
    if (m_win) begin
      m_sr = {(wr ? din : m_sr[0]), m_sr[63:1]};
      if (wr) m_wrote = 1;
      m_cnt++;
      if (m_cnt == NB) begin
        m_win = 0;
        if (m_wrote) m_shadow = m_sr;
      end
    end else if (!wr) begin
      m_ptr = 0; m_lock = 0;
    end else if (!m_lock) begin
      if (din != KEY[m_ptr]) m_lock = 1;
      else if (m_ptr == NB-1) begin
        m_ptr = 0; m_win = 1; m_cnt = 0; m_sr = m_shadow; m_wrote = 0;
      end else m_ptr++;
    end
  endfunction

  task automatic bus_cycle(input bit ce, input bit wr, input bit din, input string tag, input int hold);
    bit pre_win, exp_bit;
    pre_win = m_win;
    exp_bit = m_sr[0];
    @(negedge clk);
    ce_n = !ce; we_n = !wr; oe_n = wr; dq_in = din;
    repeat (hold) @(negedge clk);
    if (ce && pre_win && !wr) begin
      check(dq_oe === 1'b1, "R7 drive enable on window read", 64'(dq_oe), 64'd1);
      check(dq_out === exp_bit, "R7 window read bit", 64'(dq_out), 64'(exp_bit));
    end else begin
      check(dq_oe === 1'b0, "R10 no drive", 64'(dq_oe), 64'd0);
    end
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    if (ce) model_step(wr, din);
    repeat (5) @(negedge clk);
    check(win === m_win, tag, 64'(win), 64'(m_win));
    check(shq === m_shadow, "R8 shadow contents", shq, m_shadow);
  endtask

  task automatic rd(input string tag);
    bus_cycle(1, 0, 0, tag, 5);
  endtask

  task automatic noise();
    bus_cycle(0, 1'($urandom % 2), 1'($urandom % 2), "R5 deselected cycle", 5);
  endtask

  task automatic send_key(input int len, input int bad_pos, input int noise_pct, input string tag);
    for (int i = 0; i < len; i++) begin
      if (int'($urandom % 100) < noise_pct) noise();
      bus_cycle(1, 1, (i == bad_pos) ? ~KEY[i] : KEY[i], tag, 5);
    end
  endtask

  task automatic preset(input logic [63:0] v);
    @(negedge clk); ld_en = 1'b1; ld_data = v;
    @(negedge clk); ld_en = 1'b0;
    m_shadow = v;
    @(negedge clk);
    check(shq === v, "R9 preset load", shq, v);
  endtask

  initial begin
    int seed_dummy;
    logic [63:0] wdata;
    seed_dummy = $urandom(32'h51EE_D00D);
    repeat (4) @(negedge clk);
    check(win === 1'b0, "R1 window closed in reset", 64'(win), 0);
    check(dq_oe === 1'b0, "R1 no drive in reset", 64'(dq_oe), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(shq === '0, "R1 shadow cleared", shq, 0);
    check(win === 1'b0, "R1 window closed after reset", 64'(win), 0);

    // R12 power-up flush
    for (int i = 0; i < 64; i++) rd("R12 flush read");
    check(win === 1'b0, "R12 window closed after flush", 64'(win), 0);

    // R2/R7/R9 unlock then read-only window
    preset(64'h0123_4567_89AB_CDEF);
    rd("R4 prime read");
    send_key(64, -1, 0, "R2 key write");
    check(win === 1'b1, "R2 window open after full key", 64'(win), 1);
    for (int i = 0; i < 64; i++) rd("R6 window read");
    check(win === 1'b0, "R6 window closed after 64", 64'(win), 0);
    check(shq === 64'h0123_4567_89AB_CDEF, "R9 read-only window keeps shadow", shq, 64'h0123_4567_89AB_CDEF);

    // R3 mismatch lockout
    rd("R4 prime read");
    send_key(64, 10, 0, "R3 locked key write");
    check(win === 1'b0, "R3 no window after mismatch", 64'(win), 0);
    // R4 read clears lockout, then R8 write window
    rd("R4 rewind read");
    send_key(64, -1, 0, "R4 key after rewind");
    check(win === 1'b1, "R4 window after rewind", 64'(win), 1);
    wdata = 64'hFEDC_0BA9_8765_4321;
    for (int i = 0; i < 64; i++) bus_cycle(1, 1, wdata[i], "R8 window write", 5);
    check(shq === wdata, "R8 committed word", shq, wdata);

    // R5 interleaved deselected cycles, R11 long held cycles
    rd("R4 prime read");
    send_key(64, -1, 40, "R5 key with noise");
    check(win === 1'b1, "R5 window opens despite noise", 64'(win), 1);
    for (int i = 0; i < 64; i++) begin
      if (i % 7 == 0) noise();
      bus_cycle(1, 1'(i % 3 == 0), 1'($urandom % 2), "R11 window cycle", (i % 9 == 0) ? 40 : 5);
    end
    check(win === 1'b0, "R11 long cycles counted once", 64'(win), 0);
    check(shq === m_shadow, "R8 mixed window commit", shq, m_shadow);

    // R4 partial key then rewind
    send_key(30, -1, 0, "R4 partial key");
    rd("R4 abort read");
    send_key(64, -1, 0, "R4 key after abort");
    check(win === 1'b1, "R4 window after abort", 64'(win), 1);
    for (int i = 0; i < 64; i++) rd("R6 window read");
    // R6 back to matching from bit 0
    send_key(64, -1, 0, "R6 key right after window");
    check(win === 1'b1, "R6 matching restarts at bit 0", 64'(win), 1);
    for (int i = 0; i < 64; i++) rd("R7 window read");

    // random trials
    for (int t = 0; t < 12; t++) begin
      int kind;
      kind = int'($urandom % 3);
      if (!m_win) rd("R4 prime read");
      if (kind == 0) begin
        send_key(64, -1, 15, "R2 random key");
        for (int i = 0; i < 64; i++) begin
          if ($urandom % 100 < 15) noise();
          bus_cycle(1, 1'($urandom % 2), 1'($urandom % 2), "R6 random window", 5);
        end
      end else if (kind == 1) begin
        send_key(64, int'($urandom % 64), 15, "R3 random mismatch");
      end else begin
        send_key(int'($urandom % 63) + 1, -1, 15, "R4 random partial");
        rd("R4 random abort");
      end
      if ($urandom % 4 == 0 && !m_win) preset({$urandom, $urandom});
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule